// File: doc/BRIEF.md
# Two-Way Instruction Cache Controller

This block serves instruction fetches from a processor core through a small two-way set-associative cache that holds 256 sets of four-word lines. Each fetch looks up both ways of the set picked by its address. A hit answers from the on-chip array. A miss issues one wrapping burst of four beats on an internal bus. The beat the core asked for comes first and goes straight to the core in the cycle it arrives. The other beats then fill a victim line. The victim is an empty way when one exists and otherwise the least recently used way of the set.

A fetch whose top address bit is set never allocates. It is served by a single-beat bus read and leaves the replacement state untouched. When the enable input is low, all tags are dropped and the data array works as 8 KB of directly mapped on-chip RAM. It is reached through a fixed window that starts at byte 0xFFE00000, and the core may read it and write it. Every other access in that mode goes to the bus as a single read.

The core request and the bus request are valid/ready streams. A source keeps valid and its payload steady until ready is seen, and the handshake is complete on the clock edge where both are high. The core response and the bus read beats have no back-pressure on the core side. The core must take a response in the cycle it is valid. While a fill is under way the controller holds `bus_rd_ready` high. It lowers `req_ready` for as long as a bus transfer is pending, and this is its only back-pressure.

Top module: `icache_two_way`

## Requirements
- R1: A cacheable read (enable high, address bit 31 clear) that hits returns the stored word with `rsp_valid` high exactly one cycle after the request handshake, and starts no bus request.
- R2: A cacheable read that misses raises `bus_req_valid` with `bus_req_burst`=1 and `bus_req_addr` equal to the word-aligned fetch address. The four beats arrive in wrapping order: the requested word, then the following words modulo 4 within the line. They fill the line, so that later reads of any of its four words hit. Address bits [3:2] select the word, bits [11:4] the set, and bits [31:12] form the tag.
- R3: The first beat of any bus read is presented on `rsp_data` with `rsp_valid` high in the same cycle as that beat's handshake. Each read request produces exactly one response.
- R4: On a miss the controller fills an invalid way of the set if there is one, and otherwise the least recently used way. A hit and a completed fill both mark the way used as most recent.
- R5: A read with address bit 31 set issues a single-beat bus read (`bus_req_burst`=0). It allocates no line and does not change the replacement order, so repeating it goes to the bus again.
- R6: From the handshake of a read that needs the bus until the cycle after its last beat, `req_ready` stays low.
- R7: With enable low, an access to the 8 KB window at 0xFFE00000 goes straight to the array. The way is byte address bit 12, the set is bits [11:4] and the word is bits [3:2]. A read answers one cycle after the handshake. A write updates the array and gives no response. Any other read in this mode is a single-beat bus read.
- R8: Dropping the enable invalidates every line, so that after re-enabling, the first read of a line that was cached before misses.
- R9: A write outside the RAM window, or any write while the cache is enabled, is accepted and dropped. It gives no response, starts no bus traffic and leaves cached words unchanged.
- R10: After reset, no line is valid, `req_ready` is high, and `rsp_valid` and `bus_req_valid` are low.
- R11: Once raised, `bus_req_valid` stays high with a steady address until `bus_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable; low selects on-chip RAM mode |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller accepts a request |
| req_addr | input | 32 | Request byte address |
| req_we | input | 1 | Request is a write (RAM mode only takes effect) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid (no back-pressure) |
| rsp_data | output | 32 | Read response word |
| bus_req_valid | output | 1 | Bus read request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_addr | output | 32 | Word-aligned address of the first beat |
| bus_req_burst | output | 1 | 1 = four-beat wrapping burst, 0 = single beat |
| bus_rd_valid | input | 1 | Bus read beat valid |
| bus_rd_ready | output | 1 | Controller takes a beat |
| bus_rd_data | input | 32 | Bus read beat data |

## Verification
Fetches start at every word offset of a line. A miss on word 2 followed by reads of the other three words separates a correct wrapping fill from a linear one or a partial one. Three tags that conflict in one set are fetched in an interleaved order that tells least-recently-used replacement apart from first-in and from fixed-way choices, and shows whether a hit refreshes the order. Bit-31 reads repeated at one address show whether such reads allocate. RAM-mode writes to both halves of the window, followed by read-backs and a re-enable, show the way-bit mapping and that disabling the cache drops every tag. Bus latency varies from beat to beat, which exercises both the forwarding of the first word and the stall.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BREQ = 2'd1,
    ST_FILL = 2'd2
  } ictl_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       lk_hit,
  output logic             lk_victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [1:0]      lk_vld;
  logic [SETS-1:0] lru_q;   // per set: way to replace next

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             sel;
    assign sel = fill_en && (touch_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= '0;
      else if (!en) vld_q <= '0;
      else if (sel) vld_q[touch_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_mem[touch_set] <= fill_tag;
    end

    assign lk_vld[w] = vld_q[lk_set];
    assign lk_hit[w] = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= ~touch_way;
  end

  assign lk_victim = !lk_vld[0] ? 1'b0 :
                     !lk_vld[1] ? 1'b1 : lru_q[lk_set];
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int SETS  = 256,
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int DEPTH = 2 * SETS * WORDS
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [OFF_W-1:0] rd_word,
  output logic [1:0][31:0] rd_data,
  input  logic             we,
  input  logic             wr_way,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [OFF_W-1:0] wr_word,
  input  logic [31:0]      wr_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wr_way, wr_set, wr_word}] <= wr_data;
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_data[w] = mem[{1'(w), rd_set, rd_word}];
  end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int          SETS     = 256,
  parameter int          WORDS    = 4,
  parameter logic [31:0] RAM_BASE = 32'hFFE0_0000,
  localparam int IDX_W   = $clog2(SETS),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int TAG_W   = 32 - IDX_W - OFF_W - 2,
  localparam int WBIT    = 2 + OFF_W + IDX_W,
  localparam int WIN_LSB = WBIT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cache_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_we,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             bus_req_valid,
  input  logic             bus_req_ready,
  output logic [31:0]      bus_req_addr,
  output logic             bus_req_burst,
  input  logic             bus_rd_valid,
  output logic             bus_rd_ready,
  input  logic [31:0]      bus_rd_data,
  output logic [IDX_W-1:0] lk_set,
  output logic [OFF_W-1:0] lk_word,
  output logic [TAG_W-1:0] lk_tag,
  input  logic [1:0]       lk_hit,
  input  logic             lk_victim,
  output logic             touch_en,
  output logic [IDX_W-1:0] touch_set,
  output logic             touch_way,
  output logic             fill_en,
  output logic [TAG_W-1:0] fill_tag,
  input  logic [1:0][31:0] rd_data,
  output logic             we,
  output logic             wr_way,
  output logic [IDX_W-1:0] wr_set,
  output logic [OFF_W-1:0] wr_word,
  output logic [31:0]      wr_data
);
  ictl_state_e      st_q;
  logic [31:2]      pend_q;
  logic             pend_burst_q;
  logic             pend_way_q;
  logic [OFF_W-1:0] beat_q;
  logic             rspq_v;
  logic [31:0]      rspq_d;

  logic             idle, in_win, cacheable, acc, hit, beat_fire, last_beat, fwd;
  logic [IDX_W-1:0] pend_set;
  logic [OFF_W-1:0] fill_ptr;
  logic             addr_lsb_unused;

  assign addr_lsb_unused = ^req_addr[1:0];

  assign lk_set  = req_addr[2+OFF_W +: IDX_W];
  assign lk_word = req_addr[2 +: OFF_W];
  assign lk_tag  = req_addr[31 -: TAG_W];

  assign idle      = (st_q == ST_IDLE);
  assign in_win    = !cache_en && (req_addr[31:WIN_LSB] == RAM_BASE[31:WIN_LSB]);
  assign cacheable = cache_en && !req_addr[31];
  assign req_ready = idle;
  assign acc       = idle && req_valid;
  assign hit       = cacheable && (|lk_hit);

  assign pend_set  = pend_q[2+OFF_W +: IDX_W];
  assign fill_ptr  = pend_q[2 +: OFF_W] + beat_q;
  assign beat_fire = (st_q == ST_FILL) && bus_rd_valid;
  assign last_beat = !pend_burst_q || (beat_q == OFF_W'(WORDS - 1));
  assign fill_en   = beat_fire && pend_burst_q && last_beat;
  assign fill_tag  = pend_q[31 -: TAG_W];

  assign touch_en  = (acc && !req_we && hit) || fill_en;
  assign touch_set = fill_en ? pend_set : lk_set;
  assign touch_way = fill_en ? pend_way_q : lk_hit[1];

  always_comb begin
    we      = 1'b0;
    wr_way  = pend_way_q;
    wr_set  = pend_set;
    wr_word = fill_ptr;
    wr_data = bus_rd_data;
    if (st_q == ST_FILL) begin
      we = bus_rd_valid && pend_burst_q;
    end else if (acc && req_we && in_win) begin
      we      = 1'b1;
      wr_way  = req_addr[WBIT];
      wr_set  = lk_set;
      wr_word = lk_word;
      wr_data = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      pend_q       <= '0;
      pend_burst_q <= 1'b0;
      pend_way_q   <= 1'b0;
      beat_q       <= '0;
      rspq_v       <= 1'b0;
      rspq_d       <= '0;
    end else begin
      rspq_v <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (acc && !req_we) begin
            if (in_win) begin
              rspq_v <= 1'b1;
              rspq_d <= rd_data[req_addr[WBIT]];
            end else if (hit) begin
              rspq_v <= 1'b1;
              rspq_d <= rd_data[lk_hit[1]];
            end else begin
              pend_q       <= req_addr[31:2];
              pend_burst_q <= cacheable;
              pend_way_q   <= lk_victim;
              st_q         <= ST_BREQ;
            end
          end
        end
        ST_BREQ: begin
          if (bus_req_ready) begin
            st_q   <= ST_FILL;
            beat_q <= '0;
          end
        end
        ST_FILL: begin
          if (bus_rd_valid) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (st_q == ST_BREQ);
  assign bus_req_addr  = {pend_q, 2'b00};
  assign bus_req_burst = pend_burst_q;
  assign bus_rd_ready  = (st_q == ST_FILL);

  assign fwd       = beat_fire && (beat_q == '0);
  assign rsp_valid = rspq_v || fwd;
  assign rsp_data  = fwd ? bus_rd_data : rspq_d;
endmodule

// File: rtl/icache_two_way.sv
module icache_two_way #(
  parameter int          SETS     = 256,
  parameter int          WORDS    = 4,
  parameter logic [31:0] RAM_BASE = 32'hFFE0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_we,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [31:0] bus_req_addr,
  output logic        bus_req_burst,
  input  logic        bus_rd_valid,
  output logic        bus_rd_ready,
  input  logic [31:0] bus_rd_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = 32 - IDX_W - OFF_W - 2;

  logic [IDX_W-1:0] lk_set, touch_set, wr_set;
  logic [OFF_W-1:0] lk_word, wr_word;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [1:0]       lk_hit;
  logic             lk_victim, touch_en, touch_way, fill_en, we, wr_way;
  logic [1:0][31:0] rd_data;
  logic [31:0]      wr_data;

  icache_ctrl #(.SETS(SETS), .WORDS(WORDS), .RAM_BASE(RAM_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .bus_req_burst(bus_req_burst),
    .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready), .bus_rd_data(bus_rd_data),
    .lk_set(lk_set), .lk_word(lk_word), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_victim(lk_victim),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .rd_data(rd_data), .we(we), .wr_way(wr_way), .wr_set(wr_set),
    .wr_word(wr_word), .wr_data(wr_data)
  );

  icache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .en(cache_en),
    .lk_set(lk_set), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_victim(lk_victim),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
    .fill_en(fill_en), .fill_tag(fill_tag)
  );

  icache_data #(.SETS(SETS), .WORDS(WORDS)) u_data (
    .clk(clk), .rd_set(lk_set), .rd_word(lk_word), .rd_data(rd_data),
    .we(we), .wr_way(wr_way), .wr_set(wr_set), .wr_word(wr_word), .wr_data(wr_data)
  );
endmodule

// File: rtl/icache_two_way_chk.sv
module icache_two_way_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        bus_req_valid,
  input logic        bus_req_ready,
  input logic [31:0] bus_req_addr,
  input logic        bus_req_burst,
  input logic        bus_rd_valid,
  input logic        bus_rd_ready,
  input logic [31:0] bus_rd_data
);
  logic [2:0] beats_q;
  logic       beat_hs;
  assign beat_hs = bus_rd_valid && bus_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              beats_q <= '0;
    else if (bus_req_valid && bus_req_ready) beats_q <= '0;
    else if (beat_hs && beats_q != 3'd7)     beats_q <= beats_q + 3'd1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)); // R11
  AST_STALL_DURING_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !req_ready); // R6
  AST_FIRST_BEAT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_hs && beats_q == 3'd0 |-> rsp_valid && rsp_data == bus_rd_data); // R3
  AST_READ_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_we |=> rsp_valid ^ bus_req_valid); // R1
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_we |=> !rsp_valid && !bus_req_valid); // R9
  AST_TOPBIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_addr[31] |-> !bus_req_burst); // R5
endmodule

bind icache_two_way icache_two_way_chk u_chk (.*);

// File: tb/sim_icache_two_way.sv
`timescale 1ns/1ps
module sim_icache_two_way;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_req_addr;
  logic        bus_req_burst;
  logic        bus_rd_valid = 1'b0;
  logic        bus_rd_ready;
  logic [31:0] bus_rd_data = '0;

  always #10 clk = ~clk;   // 50 MHz

  icache_two_way u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  // reference state: per-set recency list of two tags, RAM words by index
  int          mru_t [256];
  int          lru_t [256];
  int          cnt_s [256];
  logic [31:0] ref_ram [int];
  logic [31:0] exp_d [$];
  string       exp_t [$];
  logic [31:0] exp_ba [$];
  logic        exp_bb [$];
  bit          hit_due = 1'b0;
  bit          busy = 1'b0;
  int          beat_n = 0;
  int          beats_exp = 0;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5BD1_E995;
  endfunction

  function automatic bit in_win(input logic [31:0] a);
    return a[31:13] == 19'h7FF00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_ref();
    for (int s = 0; s < 256; s++) cnt_s[s] = 0;
  endtask

  // returns 1 on hit, updates recency
  function automatic bit ref_lookup(input logic [31:0] a);
    int s, t;
    s = int'(a[11:4]);
    t = int'(a[31:12]);
    if (cnt_s[s] >= 1 && mru_t[s] == t) return 1'b1;
    if (cnt_s[s] == 2 && lru_t[s] == t) begin
      lru_t[s] = mru_t[s];
      mru_t[s] = t;
      return 1'b1;
    end
    if (cnt_s[s] >= 1) lru_t[s] = mru_t[s];
    mru_t[s] = t;
    if (cnt_s[s] < 2) cnt_s[s]++;
    return 1'b0;
  endfunction

  // monitor: every negedge, compare against the reference
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (busy) chk(req_ready == 1'b0, "R6 stall while bus busy", {31'b0, req_ready}, 32'h0);
      if (hit_due) chk(rsp_valid == 1'b1, "R1/R7 response one cycle after accept", {31'b0, rsp_valid}, 32'h1);
      if (bus_rd_valid && bus_rd_ready) begin
        if (beat_n == 0) chk(rsp_valid == 1'b1, "R3 first beat forwarded same cycle", {31'b0, rsp_valid}, 32'h1);
        beat_n++;
        if (beat_n == beats_exp) begin beat_n = 0; busy = 1'b0; end
      end
      if (rsp_valid) begin
        if (exp_d.size() == 0) chk(1'b0, "R3/R9 unexpected response", rsp_data, 32'h0);
        else begin
          logic [31:0] e;
          string tg;
          e = exp_d.pop_front();
          tg = exp_t.pop_front();
          chk(rsp_data == e, tg, rsp_data, e);
        end
      end
      if (bus_req_valid && bus_req_ready) begin
        if (exp_ba.size() == 0) chk(1'b0, "R1/R9 unexpected bus request", bus_req_addr, 32'h0);
        else begin
          logic [31:0] ea;
          logic        eb;
          ea = exp_ba.pop_front();
          eb = exp_bb.pop_front();
          chk(bus_req_addr == ea, "R2/R5 bus address", bus_req_addr, ea);
          chk(bus_req_burst == eb, "R2/R5 burst flag", {31'b0, bus_req_burst}, {31'b0, eb});
        end
      end
      hit_due = 1'b0;
      if (req_valid && req_ready) begin
        if (req_we) begin
          if (!cache_en && in_win(req_addr)) ref_ram[int'(req_addr[12:2])] = req_wdata;
        end else if (!cache_en && in_win(req_addr)) begin
          exp_d.push_back(ref_ram[int'(req_addr[12:2])]);
          exp_t.push_back("R7 RAM read data");
          hit_due = 1'b1;
        end else if (cache_en && !req_addr[31]) begin
          exp_d.push_back(memw(req_addr));
          if (ref_lookup(req_addr)) begin
            exp_t.push_back("R1/R4 hit data");
            hit_due = 1'b1;
          end else begin
            exp_t.push_back("R2/R3 miss data");
            exp_ba.push_back({req_addr[31:2], 2'b00});
            exp_bb.push_back(1'b1);
            busy = 1'b1;
            beats_exp = 4;
          end
        end else begin
          exp_d.push_back(memw(req_addr));
          exp_t.push_back("R5/R7 single read data");
          exp_ba.push_back({req_addr[31:2], 2'b00});
          exp_bb.push_back(1'b0);
          busy = 1'b1;
          beats_exp = 1;
        end
      end
    end
  end

  // bus model with variable latency per beat
  logic [31:0] bm_a;
  logic        bm_b;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_req_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        @(posedge clk); #1 bus_req_ready = 1'b1;
        @(negedge clk); bm_a = bus_req_addr; bm_b = bus_req_burst;
        @(posedge clk); #1 bus_req_ready = 1'b0;
        for (int b = 0; b < (bm_b ? 4 : 1); b++) begin
          repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
          bus_rd_valid = 1'b1;
          bus_rd_data  = memw({bm_a[31:4], 2'(bm_a[3:2] + 2'(b)), 2'b00});
          @(negedge clk);
          while (!bus_rd_ready) @(negedge clk);
          @(posedge clk); #1 bus_rd_valid = 1'b0;
        end
      end
    end
  end

  task automatic fetch(input logic [31:0] a);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 begin req_valid = 1'b0; req_we = 1'b0; end
  endtask

  task automatic set_en(input logic v);
    @(posedge clk); #1 cache_en = v;
    if (!v) clear_ref();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    clear_ref();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R10 no response after reset", {31'b0, rsp_valid}, 32'h0);
    chk(bus_req_valid == 1'b0, "R10 no bus request after reset", {31'b0, bus_req_valid}, 32'h0);

    set_en(1'b1);
    // R2 wrapping fill from word 2, then every word of the line hits
    fetch(32'h0000_1008);
    fetch(32'h0000_1000); fetch(32'h0000_1004); fetch(32'h0000_100C); fetch(32'h0000_1008);
    // R4 three tags conflicting in set 0x10
    fetch(32'h0000_0100); fetch(32'h0000_1104); fetch(32'h0000_0108);
    fetch(32'h0000_2100); fetch(32'h0000_110C); fetch(32'h0000_0100);
    fetch(32'h0000_2104); fetch(32'h0000_0104); fetch(32'h0000_2108);
    // R5 bypass: repeated bit-31 reads go to the bus each time
    fetch(32'h8000_0040); fetch(32'h8000_0040); fetch(32'h0000_0044); fetch(32'h0000_004C);
    // R9 write while enabled is dropped
    wr(32'h0000_1000, 32'hDEAD_BEEF);
    fetch(32'h0000_1000);
    // R7 RAM mode
    set_en(1'b0);
    wr(32'hFFE0_0000, 32'h1111_0000);
    wr(32'hFFE0_1000, 32'h2222_1000);
    wr(32'hFFE0_1FFC, 32'h3333_1FFC);
    wr(32'hFFE0_0010, 32'h4444_0010);
    fetch(32'hFFE0_1000); fetch(32'hFFE0_0000); fetch(32'hFFE0_1FFC); fetch(32'hFFE0_0010);
    wr(32'hFFE0_0000, 32'h5555_AAAA);
    fetch(32'hFFE0_0000);
    fetch(32'h0000_1004);            // disabled, outside window: single read
    wr(32'h0000_2000, 32'h0BAD_0BAD); // R9 dropped
    fetch(32'hFFE0_1000);
    // R8 re-enable: earlier lines are gone
    set_en(1'b1);
    fetch(32'h0000_1000); fetch(32'h0000_100C); fetch(32'h0000_0100);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(exp_d.size() == 0, "R3 every read answered", exp_d.size(), 32'h0);
    chk(exp_ba.size() == 0, "R2 every expected bus request seen", exp_ba.size(), 32'h0);
    finish_run();
  end
endmodule